// File: doc/BRIEF.md
# RS-485 Driver-Enable Controller for a UART RTS Pin

This block produces the active-low RTS pin level of a UART so that the pin can also enable an RS-485 line driver. It picks one of three sources each cycle. Automatic mode has the highest priority and lets the transmit path own the pin. Hardware flow control comes next. The manual register bit is used when neither of the other two is on.

In automatic mode the pin goes active on the first transmit-FIFO write. It stays active while characters remain queued or the shift register is still busy. It is released only once the FIFO is empty and the stop bit of the last character has finished. A polarity-invert control reverses the pin sense, and it acts only in automatic mode.

The serializer, the FIFO and the flow-control logic are outside this block. It observes only their status: a FIFO write strobe, a FIFO-empty flag, a transmitter-idle flag and the flow-control RTS request.

Top module: `rs485_de_ctrl`

## Requirements
- R1: When `auto_en` is 1, the pin follows transmit activity only, and `manual_rts`, `flow_en` and `flow_rts` have no effect on it.
- R2: When `auto_en` is 0 and `flow_en` is 1, the pin equals the inverse of `flow_rts` one cycle later (request 1 gives pin 0).
- R3: When `auto_en` and `flow_en` are both 0, the pin equals the inverse of `manual_rts` one cycle later (manual bit 1 drives the pin low).
- R4: In automatic mode with `auto_inv` = 0, a cycle with `fifo_wr` = 1 makes the pin 0 (active) after the next clock edge.
- R5: In automatic mode the pin stays at its active level in every cycle after a sampled `fifo_empty` = 0 or `tx_idle` = 0. It changes to the inactive level one cycle after a cycle with `fifo_empty` = 1, `tx_idle` = 1 and `fifo_wr` = 0.
- R6: A FIFO write in the same cycle in which the last stop bit ends (`tx_idle` rising with `fifo_empty` = 1) keeps the pin active with no inactive cycle in between.
- R7: With `auto_inv` = 1 in automatic mode, the active level is 1 and the inactive level is 0.
- R8: With `auto_en` = 0, the value of `auto_inv` has no effect on the pin.
- R9: While `rst_n` is 0, the pin is set at each clock edge to the inactive level: 0 if `auto_en` and `auto_inv` are both 1, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| auto_en | input | 1 | Automatic transmit-driven mode enable |
| auto_inv | input | 1 | Pin polarity invert in automatic mode |
| flow_en | input | 1 | Hardware flow control enable |
| flow_rts | input | 1 | RTS request from flow-control logic, 1 = assert |
| manual_rts | input | 1 | Manual RTS register bit, 1 = assert |
| fifo_wr | input | 1 | Host write strobe into the transmit FIFO |
| fifo_empty | input | 1 | Transmit FIFO empty flag |
| tx_idle | input | 1 | Shift register idle, stop bit finished |
| rts_pin_n | output | 1 | RTS pin level (active low unless inverted) |

## Verification
Two events can fall in the same cycle: the end of the final stop bit, which releases the driver, and a fresh host write, which requests it again. The bench provokes this by raising `tx_idle` with the FIFO empty in exactly the cycle that carries `fifo_wr`, and then following the FIFO filling and draining. It samples the pin after every edge of that sequence and judges the case correct only if the pin never shows the inactive level until the new character has fully left. It also drives mode changes that come together with transmit activity, so that the automatic source is seen to override the flow-control and manual sources in the same cycle.

// File: rtl/rs485_de_pkg.sv
package rs485_de_pkg;
   typedef enum logic [1:0] {
      SRC_MANUAL = 2'd0,
      SRC_FLOW   = 2'd1,
      SRC_AUTO   = 2'd2
   } rts_src_e;

   // Inactive pin level for a given mode and polarity
   function automatic logic idle_level(input logic auto_on, input logic inv);
      return !(auto_on && inv);
   endfunction
endpackage

// File: rtl/rs485_tx_activity.sv
module rs485_tx_activity (
   input  logic fifo_wr,
   input  logic fifo_empty,
   input  logic tx_idle,
   output logic tx_busy
);
   // A pending write keeps the line claimed even if the shifter just went idle
   always_comb begin
      tx_busy = fifo_wr || !fifo_empty || !tx_idle;
   end
endmodule

// File: rtl/rs485_src_sel.sv
module rs485_src_sel
   import rs485_de_pkg::*;
(
   input  logic     auto_en,
   input  logic     auto_inv,
   input  logic     flow_en,
   input  logic     flow_rts,
   input  logic     manual_rts,
   input  logic     tx_busy,
   output rts_src_e src,
   output logic     pin_next
);
   always_comb begin
      if (auto_en)      src = SRC_AUTO;
      else if (flow_en) src = SRC_FLOW;
      else              src = SRC_MANUAL;
   end

   always_comb begin
      unique case (src)
         SRC_AUTO: pin_next = tx_busy ? auto_inv : !auto_inv;
         SRC_FLOW: pin_next = !flow_rts;
         default:  pin_next = !manual_rts;
      endcase
   end
endmodule

// File: rtl/rs485_de_ctrl.sv
module rs485_de_ctrl
   import rs485_de_pkg::*;
#(
   parameter int OUT_REG = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic auto_en,
   input  logic auto_inv,
   input  logic flow_en,
   input  logic flow_rts,
   input  logic manual_rts,
   input  logic fifo_wr,
   input  logic fifo_empty,
   input  logic tx_idle,
   output logic rts_pin_n
);
   localparam logic RST_PIN_NORMAL = 1'b1;

   logic     tx_busy;
   rts_src_e src;
   logic     pin_next;
   logic     rst_level;

   generate
      if (OUT_REG < 0 || OUT_REG > 1) begin : g_bad_param
         $error("rs485_de_ctrl: OUT_REG must be 0 or 1");
      end
   endgenerate

   rs485_tx_activity u_act (
      .fifo_wr    (fifo_wr),
      .fifo_empty (fifo_empty),
      .tx_idle    (tx_idle),
      .tx_busy    (tx_busy)
   );

   rs485_src_sel u_sel (
      .auto_en    (auto_en),
      .auto_inv   (auto_inv),
      .flow_en    (flow_en),
      .flow_rts   (flow_rts),
      .manual_rts (manual_rts),
      .tx_busy    (tx_busy),
      .src        (src),
      .pin_next   (pin_next)
   );

   // R9 reset value tracks the selected polarity
   always_comb begin
      rst_level = idle_level(auto_en, auto_inv) ? RST_PIN_NORMAL : 1'b0;
   end

   generate
      if (OUT_REG == 1) begin : g_reg
         logic pin_q;
         always_ff @(posedge clk) begin
            if (!rst_n) pin_q <= rst_level;
            else        pin_q <= pin_next;
         end
         assign rts_pin_n = pin_q;

         // R1 R4 R7
         auto_wr_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(auto_en) && $past(fifo_wr)
            |-> rts_pin_n == $past(auto_inv));

         // R5
         auto_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(auto_en) && ($past(!fifo_empty) || $past(!tx_idle))
            |-> rts_pin_n == $past(auto_inv));

         // R5
         auto_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(auto_en) && $past(fifo_empty) && $past(tx_idle)
            && $past(!fifo_wr)
            |-> rts_pin_n == !$past(auto_inv));

         // R2
         flow_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(!auto_en) && $past(flow_en)
            |-> rts_pin_n == !$past(flow_rts));

         // R3 R8
         manual_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(!auto_en) && $past(!flow_en)
            |-> rts_pin_n == !$past(manual_rts));
      end else begin : g_comb
         assign rts_pin_n = rst_n ? pin_next : rst_level;

         // R3
         manual_comb_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !auto_en && !flow_en |-> rts_pin_n == !manual_rts);
      end
   endgenerate
endmodule

// File: tb/rs485_de_ctrl_test.sv
`timescale 1ns/1ps
module rs485_de_ctrl_test;
   logic clk = 1'b0;
   logic rst_n;
   logic auto_en, auto_inv, flow_en, flow_rts, manual_rts;
   logic fifo_wr, fifo_empty, tx_idle;
   logic rts_pin_n;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   rs485_de_ctrl uut (
      .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .auto_inv(auto_inv),
      .flow_en(flow_en), .flow_rts(flow_rts), .manual_rts(manual_rts),
      .fifo_wr(fifo_wr), .fifo_empty(fifo_empty), .tx_idle(tx_idle),
      .rts_pin_n(rts_pin_n)
   );

   task automatic chk(input string req, input logic exp);
      checks++;
      if (rts_pin_n !== exp) begin
         failures++;
         $display("FAIL %s: rts_pin_n=%b expected=%b at %0t", req, rts_pin_n, exp, $time);
      end
   endtask

   // drive at negedge, then sample 1 ns after the following posedge
   task automatic cyc(input logic wr, input logic emp, input logic idl);
      @(negedge clk);
      fifo_wr = wr; fifo_empty = emp; tx_idle = idl;
      @(posedge clk); #1;
   endtask

   task automatic set_mode(input logic a, input logic inv, input logic fe,
                           input logic fr, input logic mr);
      @(negedge clk);
      auto_en = a; auto_inv = inv; flow_en = fe; flow_rts = fr; manual_rts = mr;
   endtask

   task automatic t_reset;
      @(negedge clk); rst_n = 1'b0;
      auto_en = 0; auto_inv = 0; flow_en = 0; flow_rts = 0; manual_rts = 0;
      fifo_wr = 0; fifo_empty = 1; tx_idle = 1;
      @(posedge clk); #1; chk("R9 normal", 1'b1);
      @(negedge clk); auto_en = 1; auto_inv = 1;
      @(posedge clk); #1; chk("R9 inverted", 1'b0);
      @(negedge clk); auto_inv = 0; auto_en = 0; manual_rts = 1;
      @(posedge clk); #1; chk("R9 manual ignored in reset", 1'b1);
      @(negedge clk); rst_n = 1'b1; manual_rts = 0;
   endtask

   task automatic t_manual;
      set_mode(0, 0, 0, 0, 1); cyc(0, 1, 1); chk("R3 manual asserted", 1'b0);
      set_mode(0, 0, 0, 0, 0); cyc(0, 1, 1); chk("R3 manual released", 1'b1);
      set_mode(0, 1, 0, 0, 1); cyc(1, 0, 0); chk("R8 inv ignored manual", 1'b0);
      set_mode(0, 1, 0, 0, 0); cyc(1, 0, 0); chk("R8 inv ignored manual off", 1'b1);
   endtask

   task automatic t_flow;
      set_mode(0, 0, 1, 1, 0); cyc(0, 1, 1); chk("R2 flow asserted", 1'b0);
      set_mode(0, 0, 1, 0, 1); cyc(0, 1, 1); chk("R2 flow over manual", 1'b1);
      set_mode(0, 1, 1, 1, 0); cyc(0, 1, 1); chk("R8 inv ignored flow", 1'b0);
   endtask

   task automatic t_auto_prio;
      set_mode(1, 0, 1, 1, 1); cyc(0, 1, 1); chk("R1 auto idle over flow/manual", 1'b1);
      set_mode(1, 0, 0, 0, 0); cyc(1, 1, 1); chk("R1 R4 write activates", 1'b0);
      cyc(0, 1, 1); chk("R5 released", 1'b1);
   endtask

   task automatic t_hold_release;
      set_mode(1, 0, 0, 0, 0);
      cyc(1, 1, 1); chk("R4 write", 1'b0);
      cyc(0, 0, 1); chk("R5 fifo pending", 1'b0);
      cyc(0, 0, 0); chk("R5 shifting with fifo", 1'b0);
      cyc(0, 1, 0); chk("R5 last char shifting", 1'b0);
      cyc(0, 1, 0); chk("R5 stop bit", 1'b0);
      cyc(0, 1, 1); chk("R5 release after stop", 1'b1);
      cyc(0, 1, 1); chk("R5 stays idle", 1'b1);
   endtask

   task automatic t_coincide;
      set_mode(1, 0, 0, 0, 0);
      cyc(1, 1, 1); chk("R6 setup write", 1'b0);
      cyc(0, 1, 0); chk("R6 last stop bit", 1'b0);
      cyc(1, 1, 1); chk("R6 write at stop end", 1'b0);
      cyc(0, 0, 1); chk("R6 fifo filled", 1'b0);
      cyc(0, 1, 0); chk("R6 new char", 1'b0);
      cyc(0, 1, 1); chk("R6 final release", 1'b1);
   endtask

   task automatic t_invert;
      set_mode(1, 1, 0, 0, 0);
      cyc(0, 1, 1); chk("R7 inverted idle", 1'b0);
      cyc(1, 1, 1); chk("R7 inverted active", 1'b1);
      cyc(0, 1, 0); chk("R7 inverted hold", 1'b1);
      cyc(0, 1, 1); chk("R7 inverted release", 1'b0);
      set_mode(1, 1, 1, 1, 1); cyc(0, 1, 1); chk("R1 inverted over flow", 1'b0);
   endtask

   initial begin
      rst_n = 1'b0;
      auto_en = 0; auto_inv = 0; flow_en = 0; flow_rts = 0; manual_rts = 0;
      fifo_wr = 0; fifo_empty = 1; tx_idle = 1;
      t_reset();
      t_manual();
      t_flow();
      t_auto_prio();
      t_hold_release();
      t_coincide();
      t_invert();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            checks++; failures++;
            $display("FAIL watchdog: done=0 expected=1");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule